// File: doc/BRIEF.md
# Daisy-Chained Bus Requester Node

This block sits between one local bus master and a shared parallel bus that has several prioritized request lines. Each request line has its own grant line, and that grant is passed from node to node along a daisy chain. The node is built for one fixed priority level. When its master wants the bus, the node pulls down the request line for that level. It then waits for the grant to reach it along the chain. When the grant arrives and the bus is free, the node takes ownership by pulling down the shared busy line and acknowledges its master.

A node that sees a grant it did not ask for passes the grant on to the next node downstream. Several masters can share one level, and the first requesting node in the chain wins. An owner gives the bus back in one of two ways:
- its master signals that it is finished, or
- the arbiter pulls the clear line, and the owner then finishes its current transfer cycle before letting go of busy.

All bus-side signals are active-low open-collector lines, modelled as a wired-AND with a pull-up. A high output means the node releases the line. The reset is synchronous and active-high.

Top module: `bus_req_node`

## Requirements
- R1: After a synchronous reset, all request outputs, the busy output and the grant-out output are high, and the acknowledge is low.
- R2: An idle node whose master raises req_i, with no grant arriving, pulls low the request line at index LEVEL on the next clock.
- R3: A requesting node samples grant-in low while busy-in is high, and the clock after that it pulls the busy line low, raises the acknowledge and releases its request line. A grant seen while busy-in is low is not taken.
- R4: A node that is neither requesting nor owning and that sees grant-in low pulls grant-out low from the next clock on. This continues for as long as grant-in stays low.
- R5: Grant-out goes high in the same cycle that grant-in goes high, with no clock edge in between.
- R6: Grant-out is never low while the node's request line is low or while it acknowledges its master.
- R7: done_i sampled high while owning releases busy and drops the acknowledge on the next clock. done_i and cyc_end_i have no effect on a node that does not own the bus.
- R8: The clear line, once seen low while owning, is remembered. The node releases the bus on the clock after cyc_end_i is sampled high. Without a clear, cyc_end_i alone does not release the bus.
- R9: A local request that arrives while a grant is being forwarded is held back and does not drive the request line until grant-in has gone high.
- R10: If req_i drops while the node is still requesting and no grant has arrived, the request line is released on the next clock.
- R11: Request lines other than the one at index LEVEL are always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Local master wants the bus (level) |
| done_i | input | 1 | Local master has finished with the bus |
| cyc_end_i | input | 1 | The current local transfer cycle ends this clock |
| ack_o | output | 1 | The node owns the bus for its master |
| br_n_o | output | LEVELS | Request lines, active low, only the LEVEL bit used |
| bg_in_n_i | input | 1 | Grant arriving from upstream for this level, active low |
| bg_out_n_o | output | 1 | Grant passed downstream, active low |
| bbsy_n_i | input | 1 | Busy line as seen on the bus, active low |
| bbsy_n_o | output | 1 | Busy drive from this node, active low |
| bclr_n_i | input | 1 | Bus clear from the arbiter, active low |

## Verification
Every internal state of this node shows directly on a port one clock after it is entered: asking appears on the request line, owning appears on the busy line and the acknowledge, and forwarding appears on grant-out. A wrong state transition is therefore visible at the next sample. The one exception is the remembered clear. An error there stays hidden until a transfer cycle ends, and then shows as a release that comes too early or never comes. For that reason the bench places cycle ends both before and after a clear pulse.

// File: rtl/bnode_pkg.sv
package bnode_pkg;

    typedef enum logic [1:0] {
        ND_IDLE = 2'd0,
        ND_ASK  = 2'd1,
        ND_HOLD = 2'd2
    } nd_state_e;

    typedef struct packed {
        nd_state_e st;
        logic      clr_seen;
    } fsm_regs_t;

    typedef struct packed {
        logic fwd;
    } fwd_regs_t;

endpackage

// File: rtl/bnode_req_fsm.sv
module bnode_req_fsm
    import bnode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic done_i,
    input  logic cyc_end_i,
    input  logic grant_act_i,
    input  logic bus_free_i,
    input  logic clr_act_i,
    input  logic fwd_act_i,
    output logic asking_o,
    output logic owning_o
);

    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ND_IDLE: begin
                r_d.clr_seen = 1'b0;
                // hold a new request back while a grant is passing through
                if (req_i && !fwd_act_i && !grant_act_i) begin
                    r_d.st = ND_ASK;
                end
            end
            ND_ASK: begin
                if (grant_act_i && bus_free_i) begin
                    r_d.st = ND_HOLD;
                end else if (!req_i && !grant_act_i) begin
                    r_d.st = ND_IDLE;
                end
            end
            ND_HOLD: begin
                if (clr_act_i) begin
                    r_d.clr_seen = 1'b1;
                end
                if (done_i || (cyc_end_i && (r_q.clr_seen || clr_act_i))) begin
                    r_d.st       = ND_IDLE;
                    r_d.clr_seen = 1'b0;
                end
            end
            default: begin
                r_d.st       = ND_IDLE;
                r_d.clr_seen = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st       <= ND_IDLE;
            r_q.clr_seen <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign asking_o = (r_q.st == ND_ASK);
    assign owning_o = (r_q.st == ND_HOLD);

endmodule

// File: rtl/bnode_grant_fwd.sv
module bnode_grant_fwd
    import bnode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic grant_act_i,
    input  logic asking_i,
    input  logic owning_i,
    output logic fwd_o
);

    fwd_regs_t f_q, f_d;

    always_comb begin
        f_d     = f_q;
        // once forwarding has started it lasts until the grant goes away
        f_d.fwd = grant_act_i && (f_q.fwd || (!asking_i && !owning_i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q.fwd <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    // gated by the live grant, so grant-out drops without waiting for an edge
    assign fwd_o = f_q.fwd && grant_act_i;

endmodule

// File: rtl/bnode_line_drv.sv
module bnode_line_drv #(
    parameter int LEVELS = 4,
    parameter int LEVEL  = 0
) (
    input  logic              asking_i,
    input  logic              owning_i,
    input  logic              fwd_i,
    output logic [LEVELS-1:0] br_n_o,
    output logic              bbsy_n_o,
    output logic              bg_out_n_o,
    output logic              ack_o
);

    for (genvar gi = 0; gi < LEVELS; gi++) begin : g_line
        if (gi == LEVEL) begin : g_own
            assign br_n_o[gi] = ~asking_i;
        end else begin : g_other
            assign br_n_o[gi] = 1'b1;
        end
    end

    assign bbsy_n_o   = ~owning_i;
    assign ack_o      = owning_i;
    assign bg_out_n_o = ~fwd_i;

endmodule

// File: rtl/bus_req_node.sv
module bus_req_node #(
    parameter int LEVELS = 4,
    parameter int LEVEL  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              done_i,
    input  logic              cyc_end_i,
    output logic              ack_o,
    output logic [LEVELS-1:0] br_n_o,
    input  logic              bg_in_n_i,
    output logic              bg_out_n_o,
    input  logic              bbsy_n_i,
    output logic              bbsy_n_o,
    input  logic              bclr_n_i
);

    logic grant_act, clr_act, bus_free;
    logic asking, owning, fwd;

    assign grant_act = ~bg_in_n_i;
    assign clr_act   = ~bclr_n_i;
    assign bus_free  = bbsy_n_i;

    bnode_req_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .done_i      (done_i),
        .cyc_end_i   (cyc_end_i),
        .grant_act_i (grant_act),
        .bus_free_i  (bus_free),
        .clr_act_i   (clr_act),
        .fwd_act_i   (fwd),
        .asking_o    (asking),
        .owning_o    (owning)
    );

    bnode_grant_fwd fwd_i (
        .clk         (clk),
        .rst         (rst),
        .grant_act_i (grant_act),
        .asking_i    (asking),
        .owning_i    (owning),
        .fwd_o       (fwd)
    );

    bnode_line_drv #(
        .LEVELS (LEVELS),
        .LEVEL  (LEVEL)
    ) drv_i (
        .asking_i   (asking),
        .owning_i   (owning),
        .fwd_i      (fwd),
        .br_n_o     (br_n_o),
        .bbsy_n_o   (bbsy_n_o),
        .bg_out_n_o (bg_out_n_o),
        .ack_o      (ack_o)
    );

endmodule

// File: rtl/bus_req_node_chk.sv
module bus_req_node_chk #(
    parameter int LEVELS = 4,
    parameter int LEVEL  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              done_i,
    input logic              ack_o,
    input logic [LEVELS-1:0] br_n_o,
    input logic              bg_in_n_i,
    input logic              bg_out_n_o,
    input logic              bbsy_n_i,
    input logic              bbsy_n_o
);

    localparam logic [LEVELS-1:0] OWN_BIT = LEVELS'(1) << LEVEL;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (bbsy_n_o && (&br_n_o) && bg_out_n_o && !ack_o)); // R1

    AST_GRANT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!br_n_o[LEVEL] && !bg_in_n_i && bbsy_n_i) |=> (!bbsy_n_o && ack_o && br_n_o[LEVEL])); // R3

    AST_FWD_FOLLOWS_IN: assert property (@(posedge clk) disable iff (rst)
        bg_in_n_i |-> bg_out_n_o); // R5

    AST_NO_FWD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        !bg_out_n_o |-> (!ack_o && br_n_o[LEVEL])); // R6

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ack_o && done_i) |=> (bbsy_n_o && !ack_o)); // R7

    AST_OTHER_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
        ((br_n_o | OWN_BIT) == {LEVELS{1'b1}})); // R11

endmodule

bind bus_req_node bus_req_node_chk #(
    .LEVELS (LEVELS),
    .LEVEL  (LEVEL)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .done_i     (done_i),
    .ack_o      (ack_o),
    .br_n_o     (br_n_o),
    .bg_in_n_i  (bg_in_n_i),
    .bg_out_n_o (bg_out_n_o),
    .bbsy_n_i   (bbsy_n_i),
    .bbsy_n_o   (bbsy_n_o)
);

// File: tb/bus_req_node_tb_top.sv
`timescale 1ns/1ps
module bus_req_node_tb_top;

    localparam int LEVELS = 4;
    localparam int LEVEL  = 2;
    localparam logic [LEVELS-1:0] ALL_HI = '1;
    localparam logic [LEVELS-1:0] ASK_V  = ALL_HI & ~(LEVELS'(1) << LEVEL);

    logic clk = 1'b0;
    logic rst, req, done, cyc_end, bg_in_n, bclr_n, other_bsy_n;
    logic ack, bg_out_n, bbsy_n_o, bbsy_bus_n;
    logic [LEVELS-1:0] br_n;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // wired-AND busy line shared with another master
    assign bbsy_bus_n = bbsy_n_o & other_bsy_n;

    bus_req_node #(.LEVELS(LEVELS), .LEVEL(LEVEL)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .done_i     (done),
        .cyc_end_i  (cyc_end),
        .ack_o      (ack),
        .br_n_o     (br_n),
        .bg_in_n_i  (bg_in_n),
        .bg_out_n_o (bg_out_n),
        .bbsy_n_i   (bbsy_bus_n),
        .bbsy_n_o   (bbsy_n_o),
        .bclr_n_i   (bclr_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // check all outputs against an expected state; R11 folded in through br
    task automatic chk_all(input string tag, input logic [LEVELS-1:0] br_e,
                           input logic bsy_e, input logic ack_e, input logic bgo_e);
        chk({tag, " br"}, 32'(br_n), 32'(br_e));
        chk({tag, " bbsy"}, 32'(bbsy_n_o), 32'(bsy_e));
        chk({tag, " ack"}, 32'(ack), 32'(ack_e));
        chk({tag, " bg_out"}, 32'(bg_out_n), 32'(bgo_e));
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; req = 0; done = 0; cyc_end = 0;
        bg_in_n = 1; bclr_n = 1; other_bsy_n = 1;
        step(); step();
        rst = 1'b0;
        chk_all("R1 reset", ALL_HI, 1, 0, 1);

        // R7: done and cycle-end ignored when not owning, all combos
        for (int k = 0; k < 8; k++) begin
            done = k[0]; cyc_end = k[1]; bclr_n = k[2];
            step();
            chk_all("R7 idle ignore", ALL_HI, 1, 0, 1);
        end
        done = 0; cyc_end = 0; bclr_n = 1;

        // R2 request
        req = 1; step();
        chk_all("R2 request", ASK_V, 1, 0, 1);

        // R3 grant while another master still busy is not taken
        other_bsy_n = 0; bg_in_n = 0; step();
        chk_all("R3 busy wait", ASK_V, 1, 0, 1);
        other_bsy_n = 1; step();
        chk_all("R3 take", ALL_HI, 0, 1, 1);
        bg_in_n = 1; step();
        chk_all("R3 hold", ALL_HI, 0, 1, 1);

        // R8 cycle end without clear keeps the bus
        cyc_end = 1; step();
        chk_all("R8 no clear", ALL_HI, 0, 1, 1);
        cyc_end = 0; bclr_n = 0; step();
        bclr_n = 1; step();
        chk_all("R8 clear remembered", ALL_HI, 0, 1, 1);
        req = 0; cyc_end = 1; step();
        chk_all("R8 release", ALL_HI, 1, 0, 1);
        cyc_end = 0;

        // R8 clear and cycle end in the same clock
        req = 1; step(); bg_in_n = 0; step(); bg_in_n = 1; req = 0;
        chk_all("R8 own again", ALL_HI, 0, 1, 1);
        bclr_n = 0; cyc_end = 1; step();
        chk_all("R8 same clock", ALL_HI, 1, 0, 1);
        bclr_n = 1; cyc_end = 0;

        // R7 done release
        req = 1; step(); bg_in_n = 0; step(); bg_in_n = 1; req = 0; step();
        chk_all("R7 owning", ALL_HI, 0, 1, 1);
        done = 1; step();
        chk_all("R7 done", ALL_HI, 1, 0, 1);
        done = 0; step();

        // R4 forwarding an unrequested grant
        bg_in_n = 0; #1;
        chk("R4 not yet", 32'(bg_out_n), 32'd1);
        step();
        chk_all("R4 forward", ALL_HI, 1, 0, 0);
        // R9 local request held back while forwarding
        req = 1; step();
        chk_all("R9 held", ALL_HI, 1, 0, 0);
        step();
        chk_all("R6 still forwarding", ALL_HI, 1, 0, 0);
        // R5 grant-out drops with grant-in, no edge
        bg_in_n = 1; #1;
        chk("R5 drop", 32'(bg_out_n), 32'd1);
        step();
        chk_all("R9 released request", ASK_V, 1, 0, 1);

        // R10 withdraw before grant
        req = 0; step();
        chk_all("R10 withdraw", ALL_HI, 1, 0, 1);

        // R1 reset while owning
        req = 1; step(); bg_in_n = 0; step(); bg_in_n = 1;
        rst = 1; step(); rst = 0; req = 0;
        chk_all("R1 reset owning", ALL_HI, 1, 0, 1);

        finish_run();
    end

endmodule